// File: doc/BRIEF.md
# Halfword-to-Word Register Access Adapter

This adapter sits between a host bus that can move only 16 bits at a time and a bank of 32-bit registers. It lets the host read or write a whole register as one indivisible operation while spending two halfword transfers on it. The low halfword carries the cost of the actual register access on reads. The high halfword carries that cost on writes.

A low-half write is parked in a write holding register and does not touch the register bank. The following high-half write joins its data with the parked half and emits one 32-bit write. On reads the order is reversed. A low-half read fetches the full word, returns the lower 16 bits and keeps the upper 16 bits in a read holding register. The high-half read is then answered from that register, so a counter that moves between the two reads still yields a consistent pair.

Full-word accesses go straight through. Byte-wide and reserved access sizes are refused with an error response. Each request gets its response exactly one cycle later.

Top module: `hw2w_adapter`

## Requirements
- R1: After reset both holding registers are zero. A high-half read with no earlier low-half read returns zero. A high-half write with no earlier low-half write stores zero in bits 15:0.
- R2: A halfword write (size code 2'b01) with address bit 1 = 0 only stores data bits 15:0 in the write holding register. It makes no register access and responds without error.
- R3: A halfword write with address bit 1 = 1 issues exactly one register write with data {host data bits 15:0, write holding register}.
- R4: A halfword read with address bit 1 = 0 issues one register read and responds with the word's bits 15:0, zero-extended to 32 bits.
- R5: The same low-half read stores the word's bits 31:16 in the read holding register. A later high-half read returns that value zero-extended, makes no register access, and is not affected by register changes made in between.
- R6: Size code 2'b00 (byte) and 2'b11 (reserved) are rejected. The response has the error flag set and zero data. No register access is made and neither holding register changes.
- R7: Size code 2'b10 (word) passes reads and writes straight through with the full 32-bit data. Neither holding register changes.
- R8: Every request cycle produces exactly one response one clock later. A cycle with no request produces none. Write responses carry zero data.
- R9: Every register access uses the request address with bits 1:0 cleared.
- R10: The write holding register keeps its value across high-half writes, so one low-half write serves any number of following high-half writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host request valid for this cycle |
| h_we | input | 1 | Host request is a write |
| h_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| h_addr | input | AW | Host byte address |
| h_wdata | input | 2*HALF_W | Host write data (low half used for halfword writes) |
| h_rsp_valid | output | 1 | Response valid, one cycle after the request |
| h_rsp_err | output | 1 | Response reports a rejected access size |
| h_rsp_data | output | 2*HALF_W | Response read data |
| r_req | output | 1 | Register access strobe |
| r_we | output | 1 | Register access is a write |
| r_addr | output | AW | Word-aligned register address |
| r_wdata | output | 2*HALF_W | Register write data |
| r_rdata | input | 2*HALF_W | Register read data, valid in the same cycle as r_req |

## Verification
The bench builds the adapter with AW = 6 and HALF_W = 16. The register bank model then has 16 words and covers the whole address space. Every merged write can therefore be read back through the adapter's own word path at any address. With 16-bit halves, distinct constants in each half show whether a returned half came from the live register or from a holding register. This setting also makes any skipped or extra register access visible during the live change between a low-half and a high-half read.

// File: rtl/hw2w_pkg.sv
package hw2w_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } hw2w_size_e;

  typedef enum logic [2:0] {
    K_IDLE,
    K_BAD,
    K_WR_LO,
    K_WR_HI,
    K_RD_LO,
    K_RD_HI,
    K_WD_WR,
    K_WD_RD
  } hw2w_kind_e;

endpackage

// File: rtl/hw2w_decode.sv
module hw2w_decode
  import hw2w_pkg::*;
(
  input  logic       req,
  input  logic       we,
  input  logic [1:0] size,
  input  logic       hi_sel,
  output hw2w_kind_e kind,
  output logic       bus_req,
  output logic       bus_we,
  output logic       wlat_en,
  output logic       rsnap_en
);

  always_comb begin
    kind = K_IDLE;
    if (req) begin
      unique case (hw2w_size_e'(size))
        SZ_HALF: begin
          if (we) kind = hi_sel ? K_WR_HI : K_WR_LO;
          else    kind = hi_sel ? K_RD_HI : K_RD_LO;
        end
        SZ_WORD: kind = we ? K_WD_WR : K_WD_RD;
        default: kind = K_BAD;
      endcase
    end
  end

  always_comb begin
    bus_req  = (kind == K_WR_HI) || (kind == K_RD_LO) ||
               (kind == K_WD_WR) || (kind == K_WD_RD);
    bus_we   = (kind == K_WR_HI) || (kind == K_WD_WR);
    wlat_en  = (kind == K_WR_LO);
    rsnap_en = (kind == K_RD_LO);
  end

endmodule

// File: rtl/hw2w_wr_merge.sv
module hw2w_wr_merge #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [HALF_W-1:0] lo_in,
  input  logic [HALF_W-1:0] hi_in,
  output logic [WORD_W-1:0] merged
);

  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] lo_d;

  always_comb begin
    lo_d = lo_q;
    if (cap_en) lo_d = lo_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  assign merged = {hi_in, lo_q};

endmodule

// File: rtl/hw2w_rd_snap.sv
module hw2w_rd_snap #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [HALF_W-1:0] hi_in,
  output logic [WORD_W-1:0] snap_word
);

  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] hi_d;

  always_comb begin
    hi_d = hi_q;
    if (cap_en) hi_d = hi_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign snap_word = {{HALF_W{1'b0}}, hi_q};

endmodule

// File: rtl/hw2w_rsp.sv
module hw2w_rsp
  import hw2w_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hw2w_kind_e        kind,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] snap_word,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data
);

  logic              valid_d;
  logic              err_d;
  logic [WORD_W-1:0] data_d;

  always_comb begin
    valid_d = (kind != K_IDLE);
    err_d   = (kind == K_BAD);
    unique case (kind)
      K_WD_RD: data_d = bus_rdata;
      K_RD_LO: data_d = {{HALF_W{1'b0}}, bus_rdata[HALF_W-1:0]};
      K_RD_HI: data_d = snap_word;
      default: data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_data  <= data_d;
    end
  end

endmodule

// File: rtl/hw2w_adapter.sv
module hw2w_adapter
  import hw2w_pkg::*;
#(
  parameter int AW     = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [1:0]        h_size,
  input  logic [AW-1:0]     h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic              h_rsp_valid,
  output logic              h_rsp_err,
  output logic [WORD_W-1:0] h_rsp_data,
  output logic              r_req,
  output logic              r_we,
  output logic [AW-1:0]     r_addr,
  output logic [WORD_W-1:0] r_wdata,
  input  logic [WORD_W-1:0] r_rdata
);

  localparam int SEL_BIT    = $clog2(HALF_W / 8);
  localparam int ALIGN_BITS = SEL_BIT + 1;
  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));

  hw2w_kind_e        kind;
  logic              bus_req;
  logic              bus_we;
  logic              wlat_en;
  logic              rsnap_en;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] snap_word;

  hw2w_decode u_decode (
    .req      (h_req),
    .we       (h_we),
    .size     (h_size),
    .hi_sel   (h_addr[SEL_BIT]),
    .kind     (kind),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .wlat_en  (wlat_en),
    .rsnap_en (rsnap_en)
  );

  hw2w_wr_merge #(.HALF_W(HALF_W)) u_wr_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (wlat_en),
    .lo_in  (h_wdata[HALF_W-1:0]),
    .hi_in  (h_wdata[HALF_W-1:0]),
    .merged (merged)
  );

  hw2w_rd_snap #(.HALF_W(HALF_W)) u_rd_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (rsnap_en),
    .hi_in     (r_rdata[WORD_W-1:HALF_W]),
    .snap_word (snap_word)
  );

  hw2w_rsp #(.HALF_W(HALF_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .bus_rdata (r_rdata),
    .snap_word (snap_word),
    .rsp_valid (h_rsp_valid),
    .rsp_err   (h_rsp_err),
    .rsp_data  (h_rsp_data)
  );

  always_comb begin
    r_req   = bus_req;
    r_we    = bus_req & bus_we;
    r_addr  = bus_req ? (h_addr & ALIGN_MASK) : '0;
    unique case (kind)
      K_WR_HI: r_wdata = merged;
      K_WD_WR: r_wdata = h_wdata;
      default: r_wdata = '0;
    endcase
  end

endmodule

// File: rtl/hw2w_adapter_chk.sv
module hw2w_adapter_chk #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_req,
  input logic              h_we,
  input logic [1:0]        h_size,
  input logic              h_sel,
  input logic [WORD_W-1:0] h_wdata,
  input logic              h_rsp_valid,
  input logic              h_rsp_err,
  input logic [WORD_W-1:0] h_rsp_data,
  input logic              r_req,
  input logic              r_we,
  input logic [1:0]        r_addr_lo,
  input logic [WORD_W-1:0] r_wdata,
  input logic [HALF_W-1:0] r_rdata_hi
);

  logic half_a, word_a, bad_a;
  logic [HALF_W-1:0] chk_lo;
  logic [HALF_W-1:0] chk_hi;

  assign half_a = h_req && (h_size == 2'b01);
  assign word_a = h_req && (h_size == 2'b10);
  assign bad_a  = h_req && ((h_size == 2'b00) || (h_size == 2'b11));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_lo <= '0;
      chk_hi <= '0;
    end else begin
      if (half_a && h_we && !h_sel)  chk_lo <= h_wdata[HALF_W-1:0];
      if (half_a && !h_we && !h_sel) chk_hi <= r_rdata_hi;
    end
  end

  p_lo_wr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_a && h_we && !h_sel) |-> !r_req);

  p_hi_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_a && h_we && h_sel) |-> (r_req && r_we && r_wdata == {h_wdata[HALF_W-1:0], chk_lo}));

  p_lo_rd_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_a && !h_we && !h_sel) |-> (r_req && !r_we));

  p_hi_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_a && !h_we && h_sel) |-> !r_req);

  p_hi_rd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_a && !h_we && h_sel) |=> (h_rsp_data == {{HALF_W{1'b0}}, chk_hi}));

  p_bad_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_a |-> !r_req);

  p_bad_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_a |=> (h_rsp_err && h_rsp_data == '0));

  p_word_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_a |-> (r_req && r_we == h_we && (!h_we || r_wdata == h_wdata)));

  p_rsp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_req |=> h_rsp_valid);

  p_rsp_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !h_req |=> !h_rsp_valid);

  p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r_req |-> (r_addr_lo == 2'b00));

endmodule

bind hw2w_adapter hw2w_adapter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req       (h_req),
  .h_we        (h_we),
  .h_size      (h_size),
  .h_sel       (h_addr[SEL_BIT]),
  .h_wdata     (h_wdata),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_err   (h_rsp_err),
  .h_rsp_data  (h_rsp_data),
  .r_req       (r_req),
  .r_we        (r_we),
  .r_addr_lo   (r_addr[1:0]),
  .r_wdata     (r_wdata),
  .r_rdata_hi  (r_rdata[WORD_W-1:HALF_W])
);

// File: tb/hw2w_adapter_tb_top.sv
module hw2w_adapter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  logic              clk;
  logic              rst_n;
  logic              h_req;
  logic              h_we;
  logic [1:0]        h_size;
  logic [AW-1:0]     h_addr;
  logic [WORD_W-1:0] h_wdata;
  logic              h_rsp_valid;
  logic              h_rsp_err;
  logic [WORD_W-1:0] h_rsp_data;
  logic              r_req;
  logic              r_we;
  logic [AW-1:0]     r_addr;
  logic [WORD_W-1:0] r_wdata;
  logic [WORD_W-1:0] r_rdata;

  hw2w_adapter #(.AW(AW), .HALF_W(HALF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_size(h_size),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rsp_valid(h_rsp_valid),
    .h_rsp_err(h_rsp_err), .h_rsp_data(h_rsp_data), .r_req(r_req),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // register bank model
  logic [WORD_W-1:0] mem [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (r_req && r_we) begin
      mem[r_addr[5:2]] <= r_wdata;
    end
  end
  assign r_rdata = mem[r_addr[5:2]];

  // access observer
  int             acc_cnt;
  logic [AW-1:0]  last_addr;
  logic [WORD_W-1:0] last_wd;
  always @(posedge clk) begin
    if (rst_n && r_req) begin
      acc_cnt   <= acc_cnt + 1;
      last_addr <= r_addr;
      last_wd   <= r_we ? r_wdata : 'x;
    end
  end

  typedef struct {
    logic [WORD_W-1:0] d;
    logic              e;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_errors;
  int   n_rsp;
  int   n_pushed;

  function automatic void check(bit ok, string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && h_rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected response", h_rsp_data, '0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check(h_rsp_data == x.d, x.tag, h_rsp_data, x.d);
        check(h_rsp_err == x.e, {x.tag, " err"}, {31'b0, h_rsp_err}, {31'b0, x.e});
      end
    end
  end

  task automatic op(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                    input logic [WORD_W-1:0] wd, input logic [WORD_W-1:0] exp_d,
                    input logic exp_e, input int exp_acc, input logic [AW-1:0] exp_ra,
                    input logic [WORD_W-1:0] exp_wd, input string tag);
    int c0;
    exp_t x;
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
    x.d = exp_d; x.e = exp_e; x.tag = tag;
    exp_q.push_back(x);
    n_pushed++;
    c0 = acc_cnt;
    @(posedge clk);
    #1;
    check((acc_cnt - c0) == exp_acc, {tag, " access count"}, WORD_W'(acc_cnt - c0), WORD_W'(exp_acc));
    if (exp_acc == 1) begin
      check(last_addr == exp_ra, {tag, " R9 address"}, WORD_W'(last_addr), WORD_W'(exp_ra));
      if (we) check(last_wd == exp_wd, {tag, " write data"}, last_wd, exp_wd);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; h_size = 2'b00; h_addr = '0; h_wdata = '0;
  endtask

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 20000) begin
        check(1'b0, "watchdog expired", '0, '0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; n_rsp = 0; n_pushed = 0; acc_cnt = 0;
    last_addr = '0; last_wd = '0;
    h_req = 1'b0; h_we = 1'b0; h_size = 2'b00; h_addr = '0; h_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(h_rsp_valid == 1'b0, "R1 reset response idle", {31'b0, h_rsp_valid}, '0);
    check(r_req == 1'b0, "R1 reset bus idle", {31'b0, r_req}, '0);
    rst_n = 1'b1;

    // R1: holding registers are zero after reset
    op(0, 2'b01, 6'h02, 32'h0,        32'h0, 0, 0, 6'h00, 32'h0,        "R1 hi read after reset");
    op(1, 2'b01, 6'h06, 32'hBEEF,     32'h0, 0, 1, 6'h04, 32'hBEEF0000, "R1 hi write after reset");
    // R2: low write only latches
    op(1, 2'b01, 6'h08, 32'h1234,     32'h0, 0, 0, 6'h00, 32'h0,        "R2 lo write");
    // R3: merged write
    op(1, 2'b01, 6'h0A, 32'hABCD,     32'h0, 0, 1, 6'h08, 32'hABCD1234, "R3 hi write merge");
    // R10: latch reused
    op(1, 2'b01, 6'h0E, 32'h5555,     32'h0, 0, 1, 6'h0C, 32'h55551234, "R10 latch reuse");
    // R6: byte write rejected, latch kept
    op(1, 2'b00, 6'h08, 32'h00FF,     32'h0, 1, 0, 6'h00, 32'h0,        "R6 byte write");
    op(1, 2'b01, 6'h12, 32'h0001,     32'h0, 0, 1, 6'h10, 32'h00011234, "R6 latch kept");
    // R7: word write pass-through, latch kept
    op(1, 2'b10, 6'h14, 32'hCAFEF00D, 32'h0, 0, 1, 6'h14, 32'hCAFEF00D, "R7 word write");
    op(1, 2'b01, 6'h1A, 32'h0002,     32'h0, 0, 1, 6'h18, 32'h00021234, "R7 latch kept");
    // R7/R3: read back through word path
    op(0, 2'b10, 6'h08, 32'h0, 32'hABCD1234, 0, 1, 6'h08, 32'h0, "R7 word read merged");
    op(0, 2'b10, 6'h04, 32'h0, 32'hBEEF0000, 0, 1, 6'h04, 32'h0, "R3 word read first");
    // R4/R5: snapshot survives a live change
    op(0, 2'b01, 6'h08, 32'h0, 32'h00001234, 0, 1, 6'h08, 32'h0, "R4 lo read");
    op(1, 2'b10, 6'h08, 32'h0, 32'h0,        0, 1, 6'h08, 32'h0, "R5 live change");
    op(0, 2'b01, 6'h0A, 32'h0, 32'h0000ABCD, 0, 0, 6'h00, 32'h0, "R5 hi read snapshot");
    // R6: reserved and byte reads rejected, snapshot kept
    op(0, 2'b11, 6'h0C, 32'h0, 32'h0,        1, 0, 6'h00, 32'h0, "R6 reserved read");
    op(0, 2'b00, 6'h0C, 32'h0, 32'h0,        1, 0, 6'h00, 32'h0, "R6 byte read");
    op(0, 2'b01, 6'h0E, 32'h0, 32'h0000ABCD, 0, 0, 6'h00, 32'h0, "R6 snapshot kept");
    // R9: misaligned word read is aligned
    op(0, 2'b10, 6'h0F, 32'h0, 32'h55551234, 0, 1, 6'h0C, 32'h0, "R9 misaligned word read");
    op(0, 2'b10, 6'h18, 32'h0, 32'h00021234, 0, 1, 6'h18, 32'h0, "R7 word read latch kept");
    op(0, 2'b10, 6'h16, 32'h0, 32'hCAFEF00D, 0, 1, 6'h14, 32'h0, "R7 word read pass");
    // R4/R5 on another word
    op(0, 2'b01, 6'h0C, 32'h0, 32'h00001234, 0, 1, 6'h0C, 32'h0, "R4 lo read second");
    op(0, 2'b01, 6'h0E, 32'h0, 32'h00005555, 0, 0, 6'h00, 32'h0, "R5 hi read second");

    // R8: idle cycles produce no response
    idle();
    @(negedge clk);
    check(h_rsp_valid == 1'b0, "R8 no response when idle", {31'b0, h_rsp_valid}, '0);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 all responses seen", WORD_W'(exp_q.size()), '0);
    check(n_rsp == n_pushed, "R8 response count", WORD_W'(n_rsp), WORD_W'(n_pushed));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule